// File: doc/BRIEF.md
# Pixel Palette Lookup Pipeline

This block is the pixel-rate datapath of a color lookup unit. Each rising pixel clock captures a pixel index, a two-bit overlay select and the active-low blank and sync controls. One clock later it reads a 24-bit color, either from an external 256-entry table through a read port or from one of three overlay color inputs. It then registers per-channel 8-bit codes for three external converters. The blank and sync flags travel with the color codes through the same registers.

An active-low host-busy input marks the time when the host access block owns the table. While it is low, the outputs show black: the codes are zero and the blank flag stays clear. Blanking and host-busy also freeze the captured index and select. The table read port therefore does not move while those inputs are being ignored.

Top module: `pal_lookup_pipe`

## Requirements
- R1: The color codes, blank flag and sync flag change exactly two rising edges after the edge that captures their inputs. After the first edge the outputs still show the previous pixel.
- R2: When the overlay select is 0, the captured pixel index addresses the table. The 24-bit word splits into red in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R3: Overlay select values 1, 2 and 3 choose overlay colors 1, 2 and 3, with the same bit split as R2. The pixel index has no effect on the codes.
- R4: A low `blank_n` gives zero codes and `px_blank` = 1, whatever the pixel index, the overlay select or the host-busy input.
- R5: `px_sync_n` repeats `sync_n` with the latency of R1. Sync never changes the codes or `px_blank`.
- R6: When `host_cs_n` is low and `blank_n` is high, the codes are zero and `px_blank` = 0 (black, not blanking).
- R7: During reset the codes are zero, `px_blank` = 1, `px_sync_n` = 1 and `tbl_addr` = 0.
- R8: `tbl_addr` shows the index captured at the last edge with both `blank_n` and `host_cs_n` high. At other edges it holds its value, and so does the captured select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_idx | input | 8 | Pixel index into the table |
| ovl_sel | input | 2 | 0 selects the table, 1 to 3 select an overlay color |
| blank_n | input | 1 | Blanking request, active low |
| sync_n | input | 1 | Sync request, active low |
| host_cs_n | input | 1 | Host owns the table, active low; forces black |
| tbl_addr | output | 8 | Table read address |
| tbl_data | input | 24 | Table read data for `tbl_addr`, combinational |
| ovl1_rgb | input | 24 | Overlay color 1 |
| ovl2_rgb | input | 24 | Overlay color 2 |
| ovl3_rgb | input | 24 | Overlay color 3 |
| px_red | output | 8 | Red code |
| px_green | output | 8 | Green code |
| px_blue | output | 8 | Blue code |
| px_blank | output | 1 | Blanking flag, 1 = blank |
| px_sync_n | output | 1 | Sync flag, active low |

## Verification
The table address is due one edge after capture, and the codes and flags are due two edges after capture. Each scenario drives its inputs on a falling edge. It reads `tbl_addr` at the next falling edge and the codes and flags at the one after that. The latency scenario changes the inputs between the two edges, so an early or a late output shows up. The hold checks read `tbl_addr` one edge after an ignored pixel, before any valid pixel can load it again.

// File: rtl/pal_lookup_pipe.sv
module pal_lookup_pipe #(
  parameter int IDX_W = 8,
  parameter int CH_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  pix_idx,
  input  logic [1:0]        ovl_sel,
  input  logic              blank_n,
  input  logic              sync_n,
  input  logic              host_cs_n,
  output logic [IDX_W-1:0]  tbl_addr,
  input  logic [3*CH_W-1:0] tbl_data,
  input  logic [3*CH_W-1:0] ovl1_rgb,
  input  logic [3*CH_W-1:0] ovl2_rgb,
  input  logic [3*CH_W-1:0] ovl3_rgb,
  output logic [CH_W-1:0]   px_red,
  output logic [CH_W-1:0]   px_green,
  output logic [CH_W-1:0]   px_blue,
  output logic              px_blank,
  output logic              px_sync_n
);
  localparam int COL_W = 3 * CH_W;

  logic [IDX_W-1:0] s1_idx;
  logic [1:0]       s1_sel;
  logic             s1_blank, s1_sync_n, s1_host;
  logic [COL_W-1:0] pick, rgb_q;
  logic [1:0]       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_idx    <= '0;
      s1_sel    <= '0;
      s1_blank  <= 1'b1;
      s1_sync_n <= 1'b1;
      s1_host   <= 1'b0;
    end else begin
      s1_blank  <= !blank_n;
      s1_sync_n <= sync_n;
      s1_host   <= !host_cs_n;
      if (blank_n && host_cs_n) begin
        s1_idx <= pix_idx;
        s1_sel <= ovl_sel;
      end
    end
  end

  assign tbl_addr = s1_idx;

  always_comb begin
    case (s1_sel)
      2'd0:    pick = tbl_data;
      2'd1:    pick = ovl1_rgb;
      2'd2:    pick = ovl2_rgb;
      default: pick = ovl3_rgb;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rgb_q     <= '0;
      px_blank  <= 1'b1;
      px_sync_n <= 1'b1;
    end else begin
      rgb_q     <= (s1_blank || s1_host) ? '0 : pick;
      px_blank  <= s1_blank;
      px_sync_n <= s1_sync_n;
    end
  end

  assign px_red   = rgb_q[3*CH_W-1:2*CH_W];
  assign px_green = rgb_q[2*CH_W-1:CH_W];
  assign px_blue  = rgb_q[CH_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             warm <= '0;
    else if (warm != 2'd2)  warm <= warm + 2'd1;
  end

  AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    px_blank |-> (rgb_q == '0)); // R4
  AST_BLANK_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2) && $past(!blank_n, 2) |-> px_blank); // R1
  AST_HOST_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2) && $past(!host_cs_n && blank_n, 2) |-> (rgb_q == '0) && !px_blank); // R6
  AST_SYNC_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2) |-> px_sync_n == $past(sync_n, 2)); // R5
  AST_OVL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2) && $past(blank_n && host_cs_n && ovl_sel == 2'd1, 2)
    |-> rgb_q == $past(ovl1_rgb)); // R3
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (warm != 2'd0) && $past(!blank_n || !host_cs_n) |-> $stable(tbl_addr)); // R8
endmodule

// File: tb/test_pal_lookup_pipe.sv
module test_pal_lookup_pipe;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pix_idx = '0;
  logic [1:0]  ovl_sel = '0;
  logic        blank_n = 1'b0, sync_n = 1'b1, host_cs_n = 1'b1;
  logic [7:0]  tbl_addr;
  logic [23:0] tbl_data;
  logic [23:0] ovl1_rgb = 24'h112233, ovl2_rgb = 24'hA0B0C0, ovl3_rgb = 24'hFE01DC;
  logic [7:0]  px_red, px_green, px_blue;
  logic        px_blank, px_sync_n;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [23:0] col(input logic [7:0] i);
    return {i, ~i, i ^ 8'h5A};
  endfunction

  assign tbl_data = col(tbl_addr);

  pal_lookup_pipe i_pal_lookup_pipe (
    .clk(clk), .rst_n(rst_n), .pix_idx(pix_idx), .ovl_sel(ovl_sel),
    .blank_n(blank_n), .sync_n(sync_n), .host_cs_n(host_cs_n),
    .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .ovl1_rgb(ovl1_rgb), .ovl2_rgb(ovl2_rgb), .ovl3_rgb(ovl3_rgb),
    .px_red(px_red), .px_green(px_green), .px_blue(px_blue),
    .px_blank(px_blank), .px_sync_n(px_sync_n));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] i, input logic [1:0] s,
                       input logic b, input logic sy, input logic cs);
    pix_idx = i; ovl_sel = s; blank_n = b; sync_n = sy; host_cs_n = cs;
  endtask

  task automatic out_is(input string req, input logic [23:0] rgb,
                        input logic bl, input logic sy);
    chk(req, {px_red, px_green, px_blue}, rgb);
    chk(req, px_blank, bl);
    chk(req, px_sync_n, sy);
  endtask

  task automatic t_reset;
    out_is("R7", 24'h0, 1'b1, 1'b1);
    chk("R7", tbl_addr, 8'h00);
  endtask

  task automatic t_table;
    for (int k = 0; k < 4; k++) begin
      logic [7:0] i;
      i = (k == 3) ? 8'hFF : 8'(k * 77 + 3);
      drive(i, 2'd0, 1'b1, 1'b1, 1'b1);
      @(negedge clk); chk("R2", tbl_addr, i);
      @(negedge clk); out_is("R2", col(i), 1'b0, 1'b1);
    end
  endtask

  task automatic t_overlay;
    drive(8'h40, 2'd1, 1'b1, 1'b1, 1'b1);
    @(negedge clk); @(negedge clk); out_is("R3", ovl1_rgb, 1'b0, 1'b1);
    drive(8'h99, 2'd2, 1'b1, 1'b1, 1'b1);
    @(negedge clk); @(negedge clk); out_is("R3", ovl2_rgb, 1'b0, 1'b1);
    drive(8'h07, 2'd3, 1'b1, 1'b1, 1'b1);
    @(negedge clk); @(negedge clk); out_is("R3", ovl3_rgb, 1'b0, 1'b1);
    drive(8'hC3, 2'd3, 1'b1, 1'b1, 1'b1);
    @(negedge clk); @(negedge clk); out_is("R3 index ignored", ovl3_rgb, 1'b0, 1'b1);
  endtask

  task automatic t_blank;
    drive(8'h21, 2'd0, 1'b1, 1'b1, 1'b1);
    @(negedge clk); @(negedge clk);
    drive(8'h88, 2'd2, 1'b0, 1'b1, 1'b1);
    @(negedge clk); chk("R8 blank hold", tbl_addr, 8'h21);
    @(negedge clk); out_is("R4", 24'h0, 1'b1, 1'b1);
    drive(8'h88, 2'd0, 1'b0, 1'b1, 1'b0);
    @(negedge clk); @(negedge clk); out_is("R4 over host", 24'h0, 1'b1, 1'b1);
    drive(8'h88, 2'd0, 1'b1, 1'b1, 1'b1);
    @(negedge clk); @(negedge clk); chk("R8 reload", tbl_addr, 8'h88);
  endtask

  task automatic t_sync;
    drive(8'h10, 2'd0, 1'b0, 1'b0, 1'b1);
    @(negedge clk); @(negedge clk); out_is("R5 in blank", 24'h0, 1'b1, 1'b0);
    drive(8'h10, 2'd0, 1'b1, 1'b0, 1'b1);
    @(negedge clk); @(negedge clk); out_is("R5 no override", col(8'h10), 1'b0, 1'b0);
    drive(8'h10, 2'd0, 1'b1, 1'b1, 1'b1);
    @(negedge clk); @(negedge clk); out_is("R5 release", col(8'h10), 1'b0, 1'b1);
  endtask

  task automatic t_host;
    drive(8'h33, 2'd0, 1'b1, 1'b1, 1'b1);
    @(negedge clk); @(negedge clk);
    drive(8'hE0, 2'd1, 1'b1, 1'b1, 1'b0);
    @(negedge clk); chk("R8 host hold", tbl_addr, 8'h33);
    @(negedge clk); out_is("R6", 24'h0, 1'b0, 1'b1);
    drive(8'hE0, 2'd0, 1'b1, 1'b1, 1'b1);
    @(negedge clk); @(negedge clk); out_is("R6 release", col(8'hE0), 1'b0, 1'b1);
  endtask

  task automatic t_latency;
    drive(8'h00, 2'd0, 1'b0, 1'b1, 1'b1);
    @(negedge clk); @(negedge clk);
    drive(8'h05, 2'd0, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    drive(8'h06, 2'd0, 1'b0, 1'b1, 1'b1);
    out_is("R1 early", 24'h0, 1'b1, 1'b1);
    @(negedge clk); out_is("R1 due", col(8'h05), 1'b0, 1'b1);
    @(negedge clk); out_is("R1 next", 24'h0, 1'b1, 1'b1);
  endtask

  initial begin
    #(CLK_P*5000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_table();
    t_overlay();
    t_blank();
    t_sync();
    t_host();
    t_latency();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule